// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flag

This block is a 1024-word by 9-bit first-in first-out buffer whose write side and read side run on unrelated clocks. A word enters on a rising write-clock edge while `wr_en` is high and the buffer has room. A word leaves on a rising read-clock edge while `rd_en` is high and the buffer holds data. `rd_data` is registered and changes only on an accepted read. Pointers cross between the domains as Gray code through two-flop synchronisers. Each flag is computed in the domain that can never be misled by the crossing delay. Full, half-full and the upper level range are computed on the write side. Empty and the lower level range are computed on the read side.

One level flag covers both ends of the buffer. It is high when the occupancy is within an offset X of empty or within X of full. X is programmed around each reset. A falling edge on `def_n` captures the low nine data bits as a candidate offset. The level of `def_n` when reset is released then picks either that candidate or the default of 256. A small controller in the write domain tracks this sequence. It has three states: OFS_RESET, OFS_LOAD and OFS_RUN. Reset forces OFS_RESET from any state. The first write-clock edge after the synchronised reset release moves OFS_RESET to OFS_LOAD. In OFS_LOAD the offset register is loaded. The next edge moves OFS_LOAD to OFS_RUN, where the controller stays until the next reset. Writes are accepted only in OFS_RUN.

Top module: `fifo2c_pflag`

## Requirements
- R1: Accepted words are returned on `rd_data` in the order they were written, with none lost or duplicated, under any interleaving of the two unrelated clocks. A write is accepted on a rising `wr_clk` edge with `wr_en` high and `full_n` high. A read is accepted on a rising `rd_clk` edge with `rd_en` high and `empty_n` high.
- R2: While the buffer holds 1024 words, write attempts leave the stored contents and the occupancy unchanged.
- R3: While the buffer is empty, read attempts leave `rd_data` unchanged and remove nothing.
- R4: `empty_n` is low (0) when the buffer holds no words, and high (1) once writes have settled through the synchroniser. It is never high while no word is stored.
- R5: `full_n` is low (0) when 1024 words are stored, and high (1) once reads have settled. It is never high while 1024 words are stored.
- R6: `half_full` is 1 at 512 or more words and 0 at 511 or fewer.
- R7: `almost_flag` is 1 when the occupancy is at most X or at least 1024−X. It is 0 for every occupancy strictly between those limits.
- R8: A high-to-low transition of `def_n`, sampled by `wr_clk`, captures `wr_data[8:0]` as the candidate offset.
- R9: If `def_n` is 0 when reset is released, X becomes the candidate. If it is 1, X becomes 256. X is then fixed until the next reset.
- R10: If `def_n` stays 0 through a later reset with no new falling edge, the previous offset is kept, whatever `wr_data` holds.
- R11: While `rst_n` is 0 the buffer is emptied. During that time `empty_n` is 0, `full_n` is 1, `almost_flag` is 1 and `half_full` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Write word; its low 9 bits are also the offset source |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_en | input | 1 | Read request |
| rd_data | output | 9 | Registered read word |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| def_n | input | 1 | Offset define input: a falling edge captures the candidate, and its level at reset release selects the source |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_full | output | 1 | High at 512 or more words (write domain) |
| almost_flag | output | 1 | High near empty or near full by offset X |

## Verification
The bench builds the block with its default parameters: 9-bit words, a 10-bit address giving 1024 entries, a default offset of 256, and two synchroniser stages. At that depth it can drive the buffer to exactly 1024 words and try writes past it. It can also step occupancy across the 511/512 half-full boundary and across both edges of the level flag. The bench defines offsets of 0, 256 and 511. Offset 0 collapses the flag onto the empty and full states. Offset 511 leaves 512 as the only occupancy with the flag low. A retained offset is exercised across a second reset.

// File: rtl/fifo2c_pkg.sv
`timescale 1ns/1ps
package fifo2c_pkg;

    // Offset programming controller states
    typedef enum logic [1:0] {
        OFS_RESET = 2'd0,
        OFS_LOAD  = 2'd1,
        OFS_RUN   = 2'd2
    } ofs_state_e;

endpackage

// File: rtl/fifo2c_rstsync.sv
`timescale 1ns/1ps
module fifo2c_rstsync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [1:0] sync_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 2'b00;
        else         sync_q <= {sync_q[0], 1'b1};
    end

    assign srst_n = sync_q[1];
endmodule

// File: rtl/fifo2c_ptrsync.sv
`timescale 1ns/1ps
module fifo2c_ptrsync #(
    parameter int PW     = 11,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    localparam int CW = PW * STAGES;

    logic [CW-1:0] chain_q;
    logic [PW-1:0] gray_s;

    // Shift chain: newest sample at the bottom, oldest at the top
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= gray_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CW-PW-1:0], gray_in};
            end
        end
    endgenerate

    assign gray_s = chain_q[CW-1 -: PW];

    // Gray to binary: each bit is the parity of itself and all higher bits
    genvar b;
    generate
        for (b = 0; b < PW; b++) begin : g_g2b
            assign bin_out[b] = ^gray_s[PW-1:b];
        end
    endgenerate
endmodule

// File: rtl/fifo2c_ram.sv
`timescale 1ns/1ps
module fifo2c_ram #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fifo2c_ofsctl.sv
`timescale 1ns/1ps
module fifo2c_ofsctl
    import fifo2c_pkg::*;
#(
    parameter int OW      = 9,
    parameter int DEF_OFS = 256
) (
    input  logic          clk,
    input  logic          srst_n,
    input  logic          def_n,
    input  logic [OW-1:0] din,
    output logic [OW-1:0] x_off,
    output logic          run,
    output ofs_state_e    state
);
    ofs_state_e    nxt;
    logic          load;
    logic          def_d;
    logic [OW-1:0] cand;

    // Edge detect and candidate capture run through reset on purpose
    always_ff @(posedge clk) begin
        def_d <= def_n;
    end

    always_ff @(posedge clk) begin
        if (def_d && !def_n) cand <= din;
    end

    // State register
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) state <= OFS_RESET;
        else         state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            OFS_RESET: nxt = OFS_LOAD;
            OFS_LOAD:  nxt = OFS_RUN;
            OFS_RUN:   nxt = OFS_RUN;
            default:   nxt = OFS_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        run  = 1'b0;
        unique case (state)
            OFS_LOAD: load = 1'b1;
            OFS_RUN:  run  = 1'b1;
            default:  ;
        endcase
    end

    // Offset keeps its value across reset so that it can be retained
    always_ff @(posedge clk) begin
        if (load) x_off <= def_n ? OW'(DEF_OFS) : cand;
    end
endmodule

// File: rtl/fifo2c_wside.sv
`timescale 1ns/1ps
module fifo2c_wside #(
    parameter int AW = 10,
    parameter int OW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        run,
    input  logic [OW-1:0] x_off,
    input  logic [AW:0] rbin,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic [AW:0] wcount,
    output logic        we,
    output logic        full_n,
    output logic        half,
    output logic        upper
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    logic [PW-1:0] wnext;

    assign wcount = wptr - rbin;
    assign full_n = (wcount != PW'(DEPTH));
    assign we     = wr_en && run && full_n;
    assign wnext  = wptr + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    assign half  = (wcount >= PW'(HALF));
    assign upper = (wcount >= (PW'(DEPTH) - PW'(x_off)));
endmodule

// File: rtl/fifo2c_rside.sv
`timescale 1ns/1ps
module fifo2c_rside #(
    parameter int AW = 10,
    parameter int OW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [OW-1:0] x_off,
    input  logic [AW:0]   wbin,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic          re,
    output logic          empty_n,
    output logic          lower
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rcount;
    logic [PW-1:0] rnext;

    assign rcount  = wbin - rptr;
    assign empty_n = (rcount != '0);
    assign re      = rd_en && empty_n;
    assign rnext   = rptr + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (re) begin
            rptr  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
        end
    end

    // An empty buffer is inside the lower range for every offset
    assign lower = !empty_n | (rcount <= PW'(x_off));
endmodule

// File: rtl/fifo2c_pflag.sv
`timescale 1ns/1ps
module fifo2c_pflag
    import fifo2c_pkg::*;
#(
    parameter int DW      = 9,
    parameter int AW      = 10,
    parameter int DEF_OFS = 256,
    parameter int SYNC_ST = 2
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          rst_n,
    input  logic          def_n,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_full,
    output logic          almost_flag
);
    localparam int PW = AW + 1;
    localparam int OW = AW - 1;

    logic          wrst_n, rrst_n;
    logic [OW-1:0] x_off;
    logic          run;
    ofs_state_e    ofs_state;
    logic [PW-1:0] wptr_w, wgray_w, wcount_w, rbin_w;
    logic [PW-1:0] rptr_r, rgray_r, wbin_r;
    logic          we, re, upper, lower;

    fifo2c_rstsync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
    fifo2c_rstsync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

    fifo2c_ofsctl #(.OW(OW), .DEF_OFS(DEF_OFS)) u_ofs (
        .clk    (wr_clk),
        .srst_n (wrst_n),
        .def_n  (def_n),
        .din    (wr_data[OW-1:0]),
        .x_off  (x_off),
        .run    (run),
        .state  (ofs_state)
    );

    fifo2c_wside #(.AW(AW), .OW(OW)) u_wside (
        .clk    (wr_clk),
        .rst_n  (wrst_n),
        .wr_en  (wr_en),
        .run    (run),
        .x_off  (x_off),
        .rbin   (rbin_w),
        .wptr   (wptr_w),
        .wgray  (wgray_w),
        .wcount (wcount_w),
        .we     (we),
        .full_n (full_n),
        .half   (half_full),
        .upper  (upper)
    );

    fifo2c_rside #(.AW(AW), .OW(OW)) u_rside (
        .clk     (rd_clk),
        .rst_n   (rrst_n),
        .rd_en   (rd_en),
        .x_off   (x_off),
        .wbin    (wbin_r),
        .rptr    (rptr_r),
        .rgray   (rgray_r),
        .re      (re),
        .empty_n (empty_n),
        .lower   (lower)
    );

    fifo2c_ptrsync #(.PW(PW), .STAGES(SYNC_ST)) u_w2r (
        .clk (rd_clk), .rst_n (rrst_n), .gray_in (wgray_w), .bin_out (wbin_r)
    );

    fifo2c_ptrsync #(.PW(PW), .STAGES(SYNC_ST)) u_r2w (
        .clk (wr_clk), .rst_n (wrst_n), .gray_in (rgray_r), .bin_out (rbin_w)
    );

    fifo2c_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (wptr_w[AW-1:0]),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (re),
        .raddr (rptr_r[AW-1:0]),
        .rdata (rd_data)
    );

    assign almost_flag = upper | lower;
endmodule

// File: rtl/fifo2c_pflag_chk.sv
`timescale 1ns/1ps
module fifo2c_pflag_chk #(
    parameter int DW = 9,
    parameter int AW = 10,
    parameter int OW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wrst_n,
    input logic          rrst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_full,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wptr,
    input logic [AW:0]   wgray,
    input logic [AW:0]   wcount,
    input logic          run,
    input logic [OW-1:0] x_off
);
    localparam int DEPTH = 1 << AW;

    AST_WPTR_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1)); // R1

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        (!full_n && wr_en) |=> (wptr == $past(wptr))); // R2

    AST_EMPTY_HOLDS_DATA: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (!empty_n && rd_en) |=> $stable(rd_data)); // R3

    AST_GRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R4

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        wcount <= (AW+1)'(DEPTH)); // R5

    AST_FULL_HAS_HALF: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        !full_n |-> half_full); // R6

    AST_OFFSET_FROZEN: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        run |=> $stable(x_off)); // R9
endmodule

bind fifo2c_pflag fifo2c_pflag_chk #(.DW(DW), .AW(AW), .OW(OW)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .wrst_n    (wrst_n),
    .rrst_n    (rrst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .half_full (half_full),
    .rd_data   (rd_data),
    .wptr      (wptr_w),
    .wgray     (wgray_w),
    .wcount    (wcount_w),
    .run       (run),
    .x_off     (x_off)
);

// File: tb/fifo2c_pflag_tb_top.sv
`timescale 1ns/1ps
module fifo2c_pflag_tb_top;
    localparam int DEPTH = 1024;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_data;
    logic       rst_n = 1'b0;
    logic       def_n = 1'b1;
    logic       empty_n, full_n, half_full, almost_flag;

    int         checks = 0;
    int         fails  = 0;
    logic [8:0] q[$];
    bit         pend = 1'b0;
    logic [8:0] pend_val;
    string      pend_req;

    always #10   wr_clk = ~wr_clk;
    always #13.5 rd_clk = ~rd_clk;

    fifo2c_pflag dut_i (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
        .rst_n(rst_n), .def_n(def_n),
        .empty_n(empty_n), .full_n(full_n),
        .half_full(half_full), .almost_flag(almost_flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_af(input int n, input int x);
        return (n <= x) || (n >= DEPTH - x);
    endfunction

    task automatic wr_cycle(input logic en, input logic [8:0] d);
        @(negedge wr_clk);
        wr_en   = en;
        wr_data = d;
        if (en && full_n) begin
            if (q.size() >= DEPTH) chk("R5", 16'(q.size()), 16'(DEPTH - 1));
            q.push_back(d);
        end
    endtask

    task automatic rd_cycle(input logic en, input string req);
        @(negedge rd_clk);
        if (pend) begin
            chk(pend_req, 16'(rd_data), 16'(pend_val));
            pend = 1'b0;
        end
        rd_en = en;
        if (en && empty_n) begin
            if (q.size() == 0) chk("R4", 16'(empty_n), 16'(0));
            else begin
                pend_val = q.pop_front();
                pend_req = req;
                pend     = 1'b1;
            end
        end
    endtask

    task automatic settle();
        wr_cycle(1'b0, 9'h0);
        rd_cycle(1'b0, "R1");
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic check_flags(input string req, input int x);
        int n;
        settle();
        n = q.size();
        chk({req, " empty_n"}, 16'(empty_n), 16'(n != 0));
        chk({req, " full_n"},  16'(full_n),  16'(n != DEPTH));
        chk({req, " half"},    16'(half_full), 16'(n >= DEPTH/2));
        chk({req, " almost"},  16'(almost_flag), 16'(exp_af(n, x)));
    endtask

    task automatic fill_to(input int n);
        while (q.size() < n) wr_cycle(1'b1, 9'($urandom));
        wr_cycle(1'b0, 9'h0);
    endtask

    task automatic drain_to(input int n, input string req);
        settle();
        while (q.size() > n) rd_cycle(1'b1, req);
        rd_cycle(1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        q.delete();
        pend = 1'b0;
        repeat (3) @(negedge wr_clk);
        chk("R11 empty_n", 16'(empty_n), 16'(0));
        chk("R11 full_n", 16'(full_n), 16'(1));
        chk("R11 almost", 16'(almost_flag), 16'(1));
        chk("R11 half", 16'(half_full), 16'(0));
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (8) @(negedge wr_clk);
    endtask

    // R8: falling edge of def_n captures the value on wr_data
    task automatic define_ofs(input logic [8:0] v);
        @(negedge wr_clk);
        wr_en = 1'b0;
        def_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        wr_data = v;
        @(negedge wr_clk);
        def_n = 1'b0;
        repeat (2) @(negedge wr_clk);
        wr_data = 9'h0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] last;
        void'($urandom(32'd1234));

        // R9: def_n high at release selects the default offset of 256
        def_n = 1'b1;
        do_reset();
        check_flags("R4 R7", 256);

        // R1: random traffic on both clocks
        fork
            begin
                repeat (3000) wr_cycle(($urandom % 100) < 55, 9'($urandom));
                wr_cycle(1'b0, 9'h0);
            end
            begin
                repeat (2400) rd_cycle(($urandom % 100) < 50, "R1");
                rd_cycle(1'b0, "R1");
            end
        join
        drain_to(0, "R1");
        check_flags("R4", 256);

        // R6/R7 boundaries with X = 256
        fill_to(256); check_flags("R7", 256);
        fill_to(257); check_flags("R7", 256);
        fill_to(511); check_flags("R6", 256);
        fill_to(512); check_flags("R6", 256);
        fill_to(767); check_flags("R7", 256);
        fill_to(768); check_flags("R7", 256);
        fill_to(1024); check_flags("R5", 256);

        // R2: writes at full are ignored; drain verifies contents
        repeat (6) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = 9'h1AA;
            if (full_n) q.push_back(9'h1AA);
        end
        wr_cycle(1'b0, 9'h0);
        check_flags("R2", 256);
        drain_to(0, "R2");
        check_flags("R4", 256);

        // R3: reads while empty leave rd_data alone
        last = rd_data;
        repeat (6) rd_cycle(1'b1, "R3");
        rd_cycle(1'b0, "R3");
        chk("R3 rd_data", 16'(rd_data), 16'(last));
        chk("R3 empty_n", 16'(empty_n), 16'(0));
        fill_to(3);
        drain_to(0, "R3");

        // R8/R9: user offset 0
        define_ofs(9'd0);
        do_reset();
        check_flags("R9", 0);
        fill_to(1); check_flags("R9", 0);
        fill_to(1023); check_flags("R9", 0);
        fill_to(1024); check_flags("R9", 0);
        drain_to(0, "R1");

        // R10: def_n kept low through reset, wr_data changed, no new edge
        @(negedge wr_clk);
        wr_data = 9'd100;
        do_reset();
        fill_to(1); check_flags("R10", 0);
        fill_to(100); check_flags("R10", 0);
        drain_to(0, "R1");

        // R8: offset 511 leaves only occupancy 512 outside the flag
        define_ofs(9'd511);
        do_reset();
        fill_to(511); check_flags("R8", 511);
        fill_to(512); check_flags("R8", 511);
        fill_to(513); check_flags("R8", 511);
        drain_to(0, "R1");

        // R9: back to default
        @(negedge wr_clk);
        def_n = 1'b1;
        do_reset();
        fill_to(256); check_flags("R9", 256);
        fill_to(257); check_flags("R9", 256);
        drain_to(0, "R1");

        // R11: reset while holding data empties the buffer
        fill_to(40);
        do_reset();
        check_flags("R11", 256);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule